// File: doc/BRIEF.md
# Frame Base Address Shadow with Commit Interrupt

This block holds the start address of the frame buffer that a display controller scans out. Software may write a new base address at any moment. The value waits in a pending register and moves into the live scan address only on a frame-start strobe. A mid-frame change therefore never tears the picture.

Each commit raises a "base taken" event bit in a raw status register. An enable register gates that bit onto a level interrupt line. Software treats the interrupt as its vertical-blank tick. It clears the event by writing a one to a clear register.

All registers are reached through a small word-indexed port. Writes take effect on the clock edge. Reads are combinational.

Register map (word index on `cfg_addr`):

| Index | Register | Access |
|---|---|---|
| 0 | pending base | read/write |
| 1 | live base | read-only |
| 2 | enable, bit 0 | read/write |
| 3 | raw status, bit 0 | read-only |
| 4 | masked status, bit 0 | read-only |
| 5 | clear, bit 0 | write-only |

Top module: `fb_base_dbuf`

## Requirements
- R1: After reset, the pending base, live base, enable, raw status and masked status all read zero, and `irq` is low.
- R2: A write to index 0 stores `cfg_wdata` with bits [1:0] forced to zero. Reading index 0 returns that pending value.
- R3: The live base (index 1) changes only on a clock edge where `frame_start` is high. On that edge it takes the pending value held before the edge.
- R4: A base write in the same cycle as `frame_start` does not reach the live base on that edge. The live base takes the older pending value, and the new value commits at the following frame start.
- R5: Every frame-start commit sets raw status bit 0 (index 3) on the same edge.
- R6: Masked status (index 4) reads as raw status AND the enable bit (index 2, bit 0). Index 2 reads back only bit 0 of the last value written.
- R7: `irq` is high exactly when a masked status bit is set. It stays high until that bit is cleared.
- R8: Writing index 5 with bit 0 set clears raw status bit 0. Writing index 5 with bit 0 zero leaves the status unchanged, whatever the other bits hold.
- R9: When a clear of bit 0 and a frame-start commit occur on the same edge, the status bit ends up set.
- R10: With the enable bit at zero, `irq` stays low while raw status keeps recording commits.
- R11: Writes to the read-only indices 1, 3 and 4 change nothing. Index 5 and unused indices read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that marks the commit point |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data, combinational from `cfg_addr` |
| irq | output | 1 | Level interrupt, the OR of the masked status bits |

## Verification
Two situations are the hardest to reach from the ports: a clear that arrives on the very edge where a commit sets the status, and a base write that lands on the same edge as the frame strobe. The bench reaches both from a single cycle-drive task. That task raises `cfg_we` and `frame_start` together for exactly one cycle, so both events fall on one edge. The live base, pending base and status are then read back before any further stimulus. Around this, the bench sweeps a dozen base values that carry nonzero low bits, and it runs through every pairing of the enable bit with a clear that does or does not carry bit 0.

// File: rtl/fbb_pkg.sv
package fbb_pkg;

    localparam int REG_IDX_W = 3;

    // Register word indices seen on the configuration port.
    typedef enum logic [REG_IDX_W-1:0] {
        RG_BASE_NEXT = 3'd0,
        RG_BASE_LIVE = 3'd1,
        RG_INT_EN    = 3'd2,
        RG_INT_RAW   = 3'd3,
        RG_INT_MASK  = 3'd4,
        RG_INT_CLR   = 3'd5
    } reg_idx_e;

endpackage

// File: rtl/fbb_decode.sv
module fbb_decode
    import fbb_pkg::*;
(
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    output logic                 wr_base,
    output logic                 wr_en,
    output logic                 wr_clr
);

    // Only writable indices produce a strobe; read-only indices are dropped.
    always_comb begin
        wr_base = 1'b0;
        wr_en   = 1'b0;
        wr_clr  = 1'b0;
        if (we) begin
            case (idx)
                RG_BASE_NEXT: wr_base = 1'b1;
                RG_INT_EN:    wr_en   = 1'b1;
                RG_INT_CLR:   wr_clr  = 1'b1;
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/fbb_shadow.sv
module fbb_shadow #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic [ADDR_W-3:0] wdata_hi,
    input  logic              frame_start,
    output logic [ADDR_W-1:0] next_q,
    output logic [ADDR_W-1:0] live_q
);

    // Pending register: word aligned, low two bits are always zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (wr_base) begin
            next_q <= {wdata_hi, 2'b00};
        end
    end

    // Live register: copies the pending value as it stood before the edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (frame_start) begin
            live_q <= next_q;
        end
    end

endmodule

// File: rtl/fbb_evt.sv
module fbb_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic wr_en,
    input  logic wr_clr,
    input  logic wbit,
    output logic en_q,
    output logic raw_q,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_en) begin
            en_q <= wbit;
        end
    end

    // A commit takes priority over a clear on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (set_evt) begin
            raw_q <= 1'b1;
        end else if (wr_clr && wbit) begin
            raw_q <= 1'b0;
        end
    end

    assign irq = raw_q & en_q;

endmodule

// File: rtl/fb_base_dbuf.sv
module fb_base_dbuf
    import fbb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 cfg_we,
    input  logic [REG_IDX_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [ADDR_W-1:0]    cfg_rdata,
    output logic                 irq
);

    localparam int PAD_W = ADDR_W - 1;

    logic              wr_base, wr_en, wr_clr;
    logic [ADDR_W-1:0] next_q, live_q;
    logic              en_q, raw_q;

    fbb_decode u_dec (
        .we      (cfg_we),
        .idx     (cfg_addr),
        .wr_base (wr_base),
        .wr_en   (wr_en),
        .wr_clr  (wr_clr)
    );

    fbb_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_base     (wr_base),
        .wdata_hi    (cfg_wdata[ADDR_W-1:2]),
        .frame_start (frame_start),
        .next_q      (next_q),
        .live_q      (live_q)
    );

    fbb_evt u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (frame_start),
        .wr_en   (wr_en),
        .wr_clr  (wr_clr),
        .wbit    (cfg_wdata[0]),
        .en_q    (en_q),
        .raw_q   (raw_q),
        .irq     (irq)
    );

    always_comb begin
        case (cfg_addr)
            RG_BASE_NEXT: cfg_rdata = next_q;
            RG_BASE_LIVE: cfg_rdata = live_q;
            RG_INT_EN:    cfg_rdata = {{PAD_W{1'b0}}, en_q};
            RG_INT_RAW:   cfg_rdata = {{PAD_W{1'b0}}, raw_q};
            RG_INT_MASK:  cfg_rdata = {{PAD_W{1'b0}}, raw_q & en_q};
            default:      cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fb_base_dbuf_chk.sv
module fb_base_dbuf_chk
    import fbb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start,
    input logic                 cfg_we,
    input logic [REG_IDX_W-1:0] cfg_addr,
    input logic                 clr_bit,
    input logic [ADDR_W-1:0]    next_base,
    input logic [ADDR_W-1:0]    live_base,
    input logic                 raw,
    input logic                 en,
    input logic                 irq
);

    logic clr_hit;
    assign clr_hit = cfg_we && (cfg_addr == RG_INT_CLR) && clr_bit;

    AST_PEND_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        next_base[1:0] == 2'b00);                                          // R2
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live_base));                              // R3
    AST_LIVE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> live_base == $past(next_base));                    // R4
    AST_SET_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> raw);                                              // R9
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr_hit) |=> raw);                                        // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !frame_start) |=> !raw);                               // R8
    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw);                                                      // R7
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);                                                     // R10

endmodule

bind fb_base_dbuf fb_base_dbuf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .clr_bit     (cfg_wdata[0]),
    .next_base   (next_q),
    .live_base   (live_q),
    .raw         (raw_q),
    .en          (en_q),
    .irq         (irq)
);

// File: tb/fb_base_dbuf_bench.sv
`timescale 1ns/1ps
module fb_base_dbuf_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    fb_base_dbuf #(.ADDR_W(32)) u_fb_base_dbuf (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        #1;
        chk(req, {31'd0, irq}, {31'd0, exp});
    endtask

    // One cycle of stimulus, applied at a falling edge and captured by the next rising edge.
    task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d, input logic fs);
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; frame_start = fs;
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        logic [31:0] live_exp;
        logic [31:0] pend_exp;
        repeat (3) @(negedge clk);
        // R1: everything is zero while reset is asserted and just after release
        for (int a = 0; a < 8; a++) rd_chk("R1", a[2:0], 32'd0);
        irq_chk("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1", 3'd0, 32'd0);

        // R11: writes to read-only indices have no effect
        cyc(1'b1, 3'd1, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b1, 3'd3, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b1, 3'd4, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b1, 3'd6, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R11", 3'd1, 32'd0);
        rd_chk("R11", 3'd3, 32'd0);
        rd_chk("R11", 3'd4, 32'd0);
        rd_chk("R11", 3'd6, 32'd0);
        rd_chk("R11", 3'd7, 32'd0);
        cyc(1'b1, 3'd5, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R11", 3'd5, 32'd0);

        // R2 R3 R5 R8: sweep of base values carrying nonzero low bits
        live_exp = 32'd0;
        for (int i = 0; i < 12; i++) begin
            logic [31:0] d;
            d = (32'h9E37_79B9 * (i + 1)) ^ i;
            cyc(1'b1, 3'd0, d, 1'b0);
            rd_chk("R2", 3'd0, d & ~32'd3);
            rd_chk("R3", 3'd1, live_exp);
            cyc(1'b0, 3'd0, 32'd0, 1'b0);
            rd_chk("R3", 3'd1, live_exp);
            cyc(1'b0, 3'd0, 32'd0, 1'b1);
            live_exp = d & ~32'd3;
            rd_chk("R3", 3'd1, live_exp);
            rd_chk("R5", 3'd3, 32'd1);
            cyc(1'b1, 3'd5, 32'd1, 1'b0);
            rd_chk("R8", 3'd3, 32'd0);
        end

        // R4: base write coincident with the frame strobe
        pend_exp = 32'h1234_5677 & ~32'd3;
        cyc(1'b1, 3'd0, 32'h1234_5677, 1'b1);
        rd_chk("R4", 3'd1, live_exp);
        rd_chk("R4", 3'd0, pend_exp);
        cyc(1'b0, 3'd0, 32'd0, 1'b1);
        rd_chk("R4", 3'd1, pend_exp);
        cyc(1'b1, 3'd5, 32'd1, 1'b0);

        // R6: enable reads back bit 0 only
        cyc(1'b1, 3'd2, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R6", 3'd2, 32'd1);
        cyc(1'b1, 3'd2, 32'hFFFF_FFFE, 1'b0);
        rd_chk("R6", 3'd2, 32'd0);

        // R6 R7 R8 R10: every enable value against clears with and without bit 0
        for (int en = 0; en < 2; en++) begin
            for (int cv = 0; cv < 2; cv++) begin
                logic [31:0] cdat;
                cdat = (cv != 0) ? 32'd1 : 32'hFFFF_FFFE;
                cyc(1'b1, 3'd2, en, 1'b0);
                cyc(1'b0, 3'd0, 32'd0, 1'b1);
                rd_chk("R10", 3'd3, 32'd1);
                rd_chk("R6", 3'd4, en);
                irq_chk("R7", en[0]);
                cyc(1'b0, 3'd0, 32'd0, 1'b0);
                irq_chk("R7", en[0]);
                cyc(1'b1, 3'd5, cdat, 1'b0);
                rd_chk("R8", 3'd3, (cv != 0) ? 32'd0 : 32'd1);
                irq_chk("R7", en[0] && (cv == 0));
                cyc(1'b1, 3'd5, 32'd1, 1'b0);
                irq_chk("R7", 1'b0);
            end
        end

        // R9: a set and a clear on the same edge, from clear and from set
        cyc(1'b1, 3'd2, 32'd1, 1'b0);
        cyc(1'b1, 3'd5, 32'd1, 1'b1);
        rd_chk("R9", 3'd3, 32'd1);
        irq_chk("R9", 1'b1);
        cyc(1'b1, 3'd5, 32'd1, 1'b1);
        rd_chk("R9", 3'd3, 32'd1);
        cyc(1'b1, 3'd5, 32'd1, 1'b0);
        irq_chk("R8", 1'b0);

        report();
    end

endmodule